// File: doc/BRIEF.md
# Pipeline Operand Bypass Select Unit

This block picks the source of every operand that may be out of date in a five-stage integer pipeline. It decodes the instruction words held in the ID/EX, EX/MEM and MEM/WB pipeline registers. It works out which of them write a register, and to which register. It then compares those destinations with the register sources that the younger instructions read.

There are three consumers. The first two are the ALU operand inputs of the instruction in execute. The third is the write-data input of a store that has reached the memory stage. For each consumer the block drives a 2-bit select that chooses among four values: the register-file value, the ALU result in EX/MEM, the ALU result in MEM/WB, or the load data in MEM/WB. A thin set of multiplexers in the same top applies the selects to the data. Stall insertion and branch compare timing are handled elsewhere.

The block is purely combinational. It holds no state, because the pipeline registers already carry both the register fields and the values to forward.

Top module: `fwd_unit`

## Requirements
- R1: Opcode is bits 31:26. Opcode 6'h00 is register-register and writes the register in bits 15:11. Opcodes 6'h08 to 6'h0F (ALU-immediate) and 6'h23 (load) write the register in bits 20:16.
- R2: Stores (6'h2B), branches (6'h04, 6'h05) and every other opcode write no register and never act as a forwarding source.
- R3: A source field equal to register 0 always gets select 00, even when a producer names register 0.
- R4: ALU input A reads bits 25:21 of the ID/EX instruction. ALU input B reads bits 20:16. When a non-load producer in EX/MEM writes that register, the select is 01.
- R5: When only the MEM/WB producer matches, the select is 10 for a register-register or ALU-immediate producer and 11 for a load.
- R6: When both EX/MEM and MEM/WB match the same source, the EX/MEM result wins with select 01.
- R7: A load in EX/MEM never forwards to an ALU input. It also hides any older MEM/WB match for that register, so the select is 00.
- R8: Input A is a consumer for every ID/EX opcode except the "other" class. Input B is a consumer only for register-register and branch opcodes. A non-consumer gets select 00.
- R9: The store-data select compares bits 20:16 of a store in EX/MEM with the MEM/WB destination. It yields 10 (ALU result) or 11 (load data), and otherwise 00. It is never 01, and it is 00 whenever EX/MEM does not hold a store.
- R10: Each data output equals the value that its select names. For store data, code 00 passes through the store value carried in EX/MEM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_ir_i | input | 32 | Instruction in execute |
| exmem_ir_i | input | 32 | Instruction in memory stage |
| memwb_ir_i | input | 32 | Instruction in write-back |
| rf_a_i | input | DATA_W | Register-file value for ALU input A |
| rf_b_i | input | DATA_W | Register-file value for ALU input B |
| exmem_alu_i | input | DATA_W | ALU result held in EX/MEM |
| exmem_st_data_i | input | DATA_W | Store value carried in EX/MEM |
| memwb_alu_i | input | DATA_W | ALU result held in MEM/WB |
| memwb_load_i | input | DATA_W | Load data held in MEM/WB |
| sel_a_o | output | 2 | Select for ALU input A |
| sel_b_o | output | 2 | Select for ALU input B |
| sel_st_o | output | 2 | Select for store write data |
| op_a_o | output | DATA_W | Forwarded ALU input A |
| op_b_o | output | DATA_W | Forwarded ALU input B |
| st_data_o | output | DATA_W | Forwarded store write data |

## Verification
The assertions assume that every opcode outside the listed classes writes nothing. They also assume that the three instruction words are fully driven whenever they are evaluated, because the checks sample combinational selects and have no valid qualifier. The stimulus draws opcodes from the defined classes plus one "other" code. It draws register fields only from registers 0 to 3, so that matches, double matches and register-0 cases occur often. Directed vectors cover load shadowing, youngest-wins and store-data forwarding from both MEM/WB sources.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int IR_W  = 32;
  localparam int REG_W = 5;

  localparam logic [5:0] OPC_RR   = 6'h00;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_BNE  = 6'h05;

  typedef enum logic [1:0] {
    SEL_RF     = 2'b00,
    SEL_EM_ALU = 2'b01,
    SEL_WB_ALU = 2'b10,
    SEL_WB_LD  = 2'b11
  } fwd_sel_e;

  typedef enum logic [2:0] {
    CL_RR, CL_IMM, CL_LOAD, CL_STORE, CL_BRANCH, CL_NONE
  } ir_class_e;

  typedef struct packed {
    ir_class_e        cls;
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] dest;
    logic             dest_vld;
    logic             is_load;
  } ir_info_t;
endpackage

// File: rtl/fwd_decode.sv
module fwd_decode
  import fwd_pkg::*;
(
  input  logic [IR_W-1:0] ir_i,
  output ir_info_t        info_o
);
  logic [5:0] opc;
  logic       unused_low;

  assign opc        = ir_i[31:26];
  assign unused_low = ^ir_i[10:0];

  always_comb begin
    info_o.rs = ir_i[25:21];
    info_o.rt = ir_i[20:16];
    unique casez (opc)
      OPC_RR:          info_o.cls = CL_RR;
      OPC_LOAD:        info_o.cls = CL_LOAD;
      OPC_STOR:        info_o.cls = CL_STORE;
      OPC_BEQ, OPC_BNE: info_o.cls = CL_BRANCH;
      6'b001???:       info_o.cls = CL_IMM;
      default:         info_o.cls = CL_NONE;
    endcase
    info_o.dest     = (info_o.cls == CL_RR) ? ir_i[15:11] : ir_i[20:16];
    info_o.is_load  = (info_o.cls == CL_LOAD);
    // register 0 is never a real destination
    info_o.dest_vld = (info_o.cls inside {CL_RR, CL_IMM, CL_LOAD}) && (info_o.dest != '0);
  end

  always_comb begin
    AST_DEST_NONZERO: assert (!info_o.dest_vld || info_o.dest != '0) else $error("dest 0 valid"); // R3
    AST_NO_PASSIVE_DEST: assert (!(info_o.cls inside {CL_STORE, CL_BRANCH, CL_NONE}) || !info_o.dest_vld)
      else $error("non-writer has dest"); // R2
  end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter bit ALLOW_EM = 1'b1
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             used_i,
  input  logic [REG_W-1:0] em_dest_i,
  input  logic             em_vld_i,
  input  logic             em_load_i,
  input  logic [REG_W-1:0] wb_dest_i,
  input  logic             wb_vld_i,
  input  logic             wb_load_i,
  output logic [1:0]       sel_o
);
  logic live, hit_em, hit_wb;

  assign live   = used_i && (src_i != '0);
  assign hit_em = ALLOW_EM && live && em_vld_i && (em_dest_i == src_i);
  assign hit_wb = live && wb_vld_i && (wb_dest_i == src_i);

  always_comb begin
    if (hit_em)      sel_o = em_load_i ? SEL_RF : SEL_EM_ALU; // younger load shadows MEM/WB
    else if (hit_wb) sel_o = wb_load_i ? SEL_WB_LD : SEL_WB_ALU;
    else             sel_o = SEL_RF;
  end

  always_comb begin
    AST_ZERO_SRC_RF: assert (used_i && src_i != '0 || sel_o == SEL_RF) else $error("zero/unused src fwd"); // R3
    AST_NO_EM_LOAD: assert (!(sel_o == SEL_EM_ALU && em_load_i)) else $error("EX/MEM load forwarded"); // R7
    AST_WB_MATCHES: assert (!sel_o[1] || (wb_vld_i && wb_dest_i == src_i)) else $error("bad WB select"); // R5
    AST_YOUNGEST: assert (!sel_o[1] || !(ALLOW_EM && em_vld_i && em_dest_i == src_i))
      else $error("older source chosen"); // R6
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IR_W-1:0]   idex_ir_i,
  input  logic [IR_W-1:0]   exmem_ir_i,
  input  logic [IR_W-1:0]   memwb_ir_i,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [DATA_W-1:0] exmem_alu_i,
  input  logic [DATA_W-1:0] exmem_st_data_i,
  input  logic [DATA_W-1:0] memwb_alu_i,
  input  logic [DATA_W-1:0] memwb_load_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [1:0]        sel_st_o,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o,
  output logic [DATA_W-1:0] st_data_o
);
  localparam int N_STG = 3;
  localparam int S_ID  = 0;
  localparam int S_EM  = 1;
  localparam int S_WB  = 2;
  localparam int N_CON = 3;

  logic [N_STG-1:0][IR_W-1:0] irs;
  ir_info_t                   info [N_STG];
  logic                       unused_info;

  assign irs = {memwb_ir_i, exmem_ir_i, idex_ir_i};

  for (genvar g = 0; g < N_STG; g++) begin : g_dec
    fwd_decode i_dec (.ir_i(irs[g]), .info_o(info[g]));
  end

  assign unused_info = ^{info[S_ID], info[S_EM], info[S_WB]};

  // consumers: 0 = ALU A, 1 = ALU B, 2 = store data
  logic [N_CON-1:0][REG_W-1:0] con_src;
  logic [N_CON-1:0]            con_used;
  logic [N_CON-1:0][1:0]       con_sel;

  assign con_src[0]  = info[S_ID].rs;
  assign con_used[0] = info[S_ID].cls != CL_NONE;
  assign con_src[1]  = info[S_ID].rt;
  assign con_used[1] = info[S_ID].cls inside {CL_RR, CL_BRANCH};
  assign con_src[2]  = info[S_EM].rt;
  assign con_used[2] = info[S_EM].cls == CL_STORE;

  for (genvar c = 0; c < N_CON; c++) begin : g_sel
    fwd_select #(.ALLOW_EM(c != 2)) i_sel (
      .src_i     (con_src[c]),
      .used_i    (con_used[c]),
      .em_dest_i (info[S_EM].dest),
      .em_vld_i  (info[S_EM].dest_vld),
      .em_load_i (info[S_EM].is_load),
      .wb_dest_i (info[S_WB].dest),
      .wb_vld_i  (info[S_WB].dest_vld),
      .wb_load_i (info[S_WB].is_load),
      .sel_o     (con_sel[c])
    );
  end

  assign sel_a_o  = con_sel[0];
  assign sel_b_o  = con_sel[1];
  assign sel_st_o = con_sel[2];

  function automatic logic [DATA_W-1:0] pick(input logic [1:0] s, input logic [DATA_W-1:0] base);
    unique case (s)
      SEL_EM_ALU: pick = exmem_alu_i;
      SEL_WB_ALU: pick = memwb_alu_i;
      SEL_WB_LD:  pick = memwb_load_i;
      default:    pick = base;
    endcase
  endfunction

  assign op_a_o    = pick(sel_a_o, rf_a_i);
  assign op_b_o    = pick(sel_b_o, rf_b_i);
  assign st_data_o = pick(sel_st_o, exmem_st_data_i);

  always_comb begin
    AST_ST_NOT_EM: assert (sel_st_o != SEL_EM_ALU) else $error("store data from EX/MEM"); // R9
    AST_ST_ONLY_STORE: assert (info[S_EM].cls == CL_STORE || sel_st_o == SEL_RF) else $error("st sel w/o store"); // R9
    AST_B_CONSUMER: assert (info[S_ID].cls inside {CL_RR, CL_BRANCH} || sel_b_o == SEL_RF) else $error("B fwd"); // R8
  end
endmodule

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [31:0] idex, exmem, memwb;
  logic [DW-1:0] rf_a, rf_b, em_alu, em_st, wb_alu, wb_ld;
  logic [1:0] sel_a, sel_b, sel_st;
  logic [DW-1:0] op_a, op_b, st_d;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  fwd_unit #(.DATA_W(DW)) i_fwd_unit (
    .idex_ir_i(idex), .exmem_ir_i(exmem), .memwb_ir_i(memwb),
    .rf_a_i(rf_a), .rf_b_i(rf_b), .exmem_alu_i(em_alu), .exmem_st_data_i(em_st),
    .memwb_alu_i(wb_alu), .memwb_load_i(wb_ld),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .sel_st_o(sel_st),
    .op_a_o(op_a), .op_b_o(op_b), .st_data_o(st_d)
  );

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {op, rs, rt, rd, 11'h155};
  endfunction

  // producer model: returns 0 for no destination
  function automatic logic [4:0] dst(logic [31:0] ir);
    logic [5:0] op = ir[31:26];
    if (op == 6'h00) return ir[15:11];
    if (op == 6'h23 || (op >= 6'h08 && op <= 6'h0F)) return ir[20:16];
    return 5'd0;
  endfunction

  function automatic logic [1:0] exp_sel(logic [4:0] src, bit used, bit em_ok);
    if (!used || src == 0) return 2'b00;
    if (em_ok && dst(exmem) == src) return (exmem[31:26] == 6'h23) ? 2'b00 : 2'b01;
    if (dst(memwb) == src) return (memwb[31:26] == 6'h23) ? 2'b11 : 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [DW-1:0] exp_dat(logic [1:0] s, logic [DW-1:0] base);
    case (s)
      2'b01: return em_alu;
      2'b10: return wb_alu;
      2'b11: return wb_ld;
      default: return base;
    endcase
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (idex=%h exmem=%h memwb=%h)", req, act, exp, idex, exmem, memwb);
    end
  endtask

  task automatic apply_check(string tag);
    logic [5:0] iop;
    bit a_used, b_used, st_used;
    logic [1:0] ea, eb, es;
    @(negedge clk);
    @(posedge clk); #2;
    iop     = idex[31:26];
    a_used  = !(iop inside {6'h00, 6'h23, 6'h2B, 6'h04, 6'h05} || (iop >= 6'h08 && iop <= 6'h0F)) ? 1'b0 : 1'b1;
    b_used  = (iop == 6'h00 || iop == 6'h04 || iop == 6'h05);
    st_used = (exmem[31:26] == 6'h2B);
    ea = exp_sel(idex[25:21], a_used, 1'b1);
    eb = exp_sel(idex[20:16], b_used, 1'b1);
    es = exp_sel(exmem[20:16], st_used, 1'b0);
    chk({tag, " R4 R5 R6 R7 sel_a"}, DW'(sel_a), DW'(ea));
    chk({tag, " R8 R1 R2 sel_b"}, DW'(sel_b), DW'(eb));
    chk({tag, " R9 sel_st"}, DW'(sel_st), DW'(es));
    chk({tag, " R10 op_a"}, op_a, exp_dat(ea, rf_a));
    chk({tag, " R10 op_b"}, op_b, exp_dat(eb, rf_b));
    chk({tag, " R10 st_data"}, st_d, exp_dat(es, em_st));
  endtask

  task automatic set(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    idex = a; exmem = b; memwb = c;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [8];
    ops = '{6'h00, 6'h00, 6'h23, 6'h2B, 6'h04, 6'h08, 6'h0D, 6'h02};
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    set('0, '0, '0);
    rf_a = 32'hA0A0_0001; rf_b = 32'hB0B0_0002; em_alu = 32'hE1E1_0003;
    em_st = 32'h5757_0004; wb_alu = 32'hB1B1_0005; wb_ld = 32'hD1D1_0006;
    repeat (3) @(posedge clk);
    apply_check("reset_nops R3");
    rst_n = 1'b1;

    // R4: EX/MEM rr producer to A and B
    set(mk(6'h00, 5'd3, 5'd4, 5'd9), mk(6'h00, 5'd1, 5'd2, 5'd3), mk(6'h00, 5'd1, 5'd2, 5'd4));
    apply_check("dir_R4");
    // R1: imm producer uses bits 20:16, rd field ignored
    set(mk(6'h00, 5'd7, 5'd8, 5'd1), mk(6'h0A, 5'd1, 5'd7, 5'd8), mk(6'h23, 5'd1, 5'd8, 5'd7));
    apply_check("dir_R1");
    // R6: both match same source
    set(mk(6'h00, 5'd5, 5'd5, 5'd1), mk(6'h00, 5'd0, 5'd0, 5'd5), mk(6'h08, 5'd0, 5'd5, 5'd0));
    apply_check("dir_R6");
    // R7: load in EX/MEM shadows MEM/WB
    set(mk(6'h00, 5'd2, 5'd6, 5'd1), mk(6'h23, 5'd0, 5'd2, 5'd0), mk(6'h00, 5'd0, 5'd0, 5'd2));
    apply_check("dir_R7");
    // R5: MEM/WB load to A
    set(mk(6'h23, 5'd6, 5'd1, 5'd0), mk(6'h2B, 5'd0, 5'd6, 5'd0), mk(6'h23, 5'd0, 5'd6, 5'd0));
    apply_check("dir_R5_R9_load");
    // R9: store data from MEM/WB alu
    set('0, mk(6'h2B, 5'd1, 5'd9, 5'd0), mk(6'h00, 5'd1, 5'd1, 5'd9));
    apply_check("dir_R9_alu");
    // R3: reg 0 source with producer naming 0
    set(mk(6'h00, 5'd0, 5'd0, 5'd0), mk(6'h00, 5'd1, 5'd1, 5'd0), mk(6'h08, 5'd0, 5'd0, 5'd0));
    apply_check("dir_R3");
    // R2: store/branch as older instructions
    set(mk(6'h00, 5'd4, 5'd4, 5'd1), mk(6'h2B, 5'd0, 5'd4, 5'd4), mk(6'h04, 5'd4, 5'd4, 5'd4));
    apply_check("dir_R2");
    // R8: imm consumer ignores rt; "other" ignores both
    set(mk(6'h08, 5'd3, 5'd3, 5'd0), mk(6'h00, 5'd0, 5'd0, 5'd3), '0);
    apply_check("dir_R8_imm");
    set(mk(6'h02, 5'd3, 5'd3, 5'd3), mk(6'h00, 5'd0, 5'd0, 5'd3), '0);
    apply_check("dir_R8_other");

    for (int i = 0; i < 400; i++) begin
      set(mk(ops[$urandom_range(7)], 5'($urandom_range(3)), 5'($urandom_range(3)), 5'($urandom_range(3))),
          mk(ops[$urandom_range(7)], 5'($urandom_range(3)), 5'($urandom_range(3)), 5'($urandom_range(3))),
          mk(ops[$urandom_range(7)], 5'($urandom_range(3)), 5'($urandom_range(3)), 5'($urandom_range(3))));
      rf_a = $urandom; rf_b = $urandom; em_alu = $urandom;
      em_st = $urandom; wb_alu = $urandom; wb_ld = $urandom;
      apply_check("rnd");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule